// File: doc/BRIEF.md
# Half-Precision Sign-Inject and Min/Max Unit

This unit handles the non-arithmetic binary16 operations of a floating-point datapath. Each cycle it takes two 16-bit operands and an operation code. It returns one of two kinds of result. The first is a 16-bit floating result from one of three sign-injection variants or from a minimum/maximum selection. The second is a 64-bit integer result, which holds the raw operand bit pattern sign-extended.

Minimum and maximum compare the operands as floating-point values. The ordering is sign-magnitude, and both zeros count as equal. NaN handling follows a fixed preference: when the second operand is NaN, the first operand is always returned. The comparisons are quiet, so the unit produces no exception flags. Both results are registered once, so a value presented at a rising edge appears on the outputs after that edge.

Top module: `hsm_unit`

## Requirements
- R1: Operation code 0 (plain inject) gives `fres_o` = bits 14:0 of A with bit 15 taken from bit 15 of B.
- R2: Operation code 1 (negated inject) gives `fres_o` = bits 14:0 of A with bit 15 equal to the inverse of bit 15 of B.
- R3: Operation code 2 (xor inject) gives `fres_o` = A with bit 15 replaced by A[15] XOR B[15]. For all three inject codes, bits 14:0 of A pass through unchanged, including NaN payloads.
- R4: Operation code 3 (minimum) returns A when B is NaN or when A is strictly less than B, and returns B otherwise.
- R5: Operation code 4 (maximum) returns A when B is NaN or when B is less than or equal to A, and returns B otherwise.
- R6: A value is NaN when its exponent bits 14:10 are all ones and its fraction bits 9:0 are nonzero. If only A is NaN, min and max return B. If both are NaN, they return A.
- R7: The ordering is sign-magnitude over all non-NaN values, and infinities are ordinary extremes. +0 and -0 compare equal, so min(x, y) of two zeros returns B and max returns A.
- R8: Operation code 5 (move to integer) gives `xres_o` = A sign-extended from bit 15 to 64 bits and `fres_o` = 0. Every other code gives `xres_o` = 0.
- R9: Both outputs are registered with one cycle of latency. A synchronous active-low reset clears both to zero.
- R10: Operation codes 6 and 7 produce zero on both outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 3 | Operation code (0 inject, 1 negated inject, 2 xor inject, 3 min, 4 max, 5 move) |
| opa_i | input | 16 | Operand A, binary16 bit pattern |
| opb_i | input | 16 | Operand B, binary16 bit pattern |
| fres_o | output | 16 | Registered floating result |
| xres_o | output | 64 | Registered integer result |

## Verification
The assertions relate each output to the operands and operation code of the previous cycle. They therefore assume the inputs are defined, with no X or Z, at every rising edge outside reset, and that the previous cycle was also out of reset. The bench drives every input only on falling edges and holds it stable through the following rising edge. It applies reset before any operation, and the first cycle after reset is excluded from the checks. Every operand it uses, including NaN payloads, subnormals, infinities and both zeros, is a fully defined 16-bit pattern.

// File: rtl/hsm_pkg.sv
// Shared types and helpers for the half-precision sign-inject / min-max unit.
// Assumes IEEE binary16 layout: sign bit 15, exponent 14:10, fraction 9:0.
package hsm_pkg;

    localparam int HW      = 16;
    localparam int XW      = 64;
    localparam int EXP_W   = 5;
    localparam int FRAC_W  = 10;
    localparam int MAG_W   = HW - 1;
    localparam int OP_W    = 3;

    localparam logic [OP_W-1:0] OP_SGNJ  = 3'd0;
    localparam logic [OP_W-1:0] OP_SGNJN = 3'd1;
    localparam logic [OP_W-1:0] OP_SGNJX = 3'd2;
    localparam logic [OP_W-1:0] OP_MIN   = 3'd3;
    localparam logic [OP_W-1:0] OP_MAX   = 3'd4;
    localparam logic [OP_W-1:0] OP_MVX   = 3'd5;

    // Per-operand classification produced once and shared by compare and select
    typedef struct packed {
        logic             nan;
        logic             zero;
        logic             sign;
        logic [MAG_W-1:0] mag;
    } hsm_cls_t;

    // Strict less-than on two non-NaN operands under sign-magnitude ordering
    function automatic logic cls_lt(hsm_cls_t x, hsm_cls_t y);
        logic res;
        if (x.zero && y.zero)
            res = 1'b0;
        else if (x.sign != y.sign)
            res = x.sign;
        else if (!x.sign)
            res = (x.mag < y.mag);
        else
            res = (y.mag < x.mag);
        return res;
    endfunction

endpackage

// File: rtl/hsm_classify.sv
// Classifies one binary16 operand: NaN, zero of either sign, sign and magnitude.
// Assumes a defined 16-bit pattern; purely combinational.
module hsm_classify
    import hsm_pkg::*;
(
    input  logic [HW-1:0] val_i,
    output hsm_cls_t      cls_o
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = val_i[HW-2 -: EXP_W];
    assign frac_f = val_i[FRAC_W-1:0];

    // Build the classification fields
    always_comb begin
        cls_o.sign = val_i[HW-1];
        cls_o.mag  = val_i[MAG_W-1:0];
        cls_o.nan  = (&exp_f) && (|frac_f);
        cls_o.zero = (val_i[MAG_W-1:0] == '0);
    end
endmodule

// File: rtl/hsm_order.sv
// Quiet ordered comparison of two classified operands.
// Produces A<B and B<=A; both are false when either operand is NaN.
module hsm_order
    import hsm_pkg::*;
(
    input  hsm_cls_t cls_a_i,
    input  hsm_cls_t cls_b_i,
    output logic     a_lt_b_o,
    output logic     b_le_a_o
);
    logic any_nan;
    logic same_val;

    assign any_nan  = cls_a_i.nan | cls_b_i.nan;
    assign same_val = (cls_a_i.zero && cls_b_i.zero) ||
                      ((cls_a_i.sign == cls_b_i.sign) && (cls_a_i.mag == cls_b_i.mag));

    // Derive the two relations min and max need
    always_comb begin
        a_lt_b_o = !any_nan && cls_lt(cls_a_i, cls_b_i);
        b_le_a_o = !any_nan && (same_val || cls_lt(cls_b_i, cls_a_i));
    end
endmodule

// File: rtl/hsm_select.sv
// Forms the next floating and integer results from the operation code.
// Assumes the compare flags are already quiet and NaN-free.
module hsm_select
    import hsm_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  logic [HW-1:0]   opa_i,
    input  logic [HW-1:0]   opb_i,
    input  logic            b_nan_i,
    input  logic            a_lt_b_i,
    input  logic            b_le_a_i,
    output logic [HW-1:0]   fres_o,
    output logic [XW-1:0]   xres_o
);
    localparam int EXT_W = XW - HW;

    logic [MAG_W-1:0] a_body;
    assign a_body = opa_i[MAG_W-1:0];

    // Result multiplexer by operation code
    always_comb begin
        fres_o = '0;
        xres_o = '0;
        unique case (op_i)
            OP_SGNJ:  fres_o = {opb_i[HW-1], a_body};
            OP_SGNJN: fres_o = {~opb_i[HW-1], a_body};
            OP_SGNJX: fres_o = {opa_i[HW-1] ^ opb_i[HW-1], a_body};
            OP_MIN:   fres_o = (b_nan_i || a_lt_b_i) ? opa_i : opb_i;
            OP_MAX:   fres_o = (b_nan_i || b_le_a_i) ? opa_i : opb_i;
            OP_MVX:   xres_o = {{EXT_W{opa_i[HW-1]}}, opa_i};
            default: begin
                fres_o = '0;
                xres_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/hsm_unit.sv
// Top of the half-precision sign-inject / min-max unit: classify, compare,
// select, then one output register. Assumes defined inputs at each rising edge.
module hsm_unit
    import hsm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op_i,
    input  logic [HW-1:0]   opa_i,
    input  logic [HW-1:0]   opb_i,
    output logic [HW-1:0]   fres_o,
    output logic [XW-1:0]   xres_o
);
    hsm_cls_t        cls_a, cls_b;
    logic            a_lt_b, b_le_a;
    logic [HW-1:0]   fres_d;
    logic [XW-1:0]   xres_d;

    hsm_classify u_cls_a (.val_i(opa_i), .cls_o(cls_a));
    hsm_classify u_cls_b (.val_i(opb_i), .cls_o(cls_b));

    hsm_order u_order (
        .cls_a_i (cls_a),
        .cls_b_i (cls_b),
        .a_lt_b_o(a_lt_b),
        .b_le_a_o(b_le_a)
    );

    hsm_select u_sel (
        .op_i    (op_i),
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .b_nan_i (cls_b.nan),
        .a_lt_b_i(a_lt_b),
        .b_le_a_i(b_le_a),
        .fres_o  (fres_d),
        .xres_o  (xres_d)
    );

    // Output register with synchronous active-low clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fres_o <= '0;
            xres_o <= '0;
        end else begin
            fres_o <= fres_d;
            xres_o <= xres_d;
        end
    end

    // Assertions relate registered outputs to the previous cycle's inputs
    p_sgnj_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_SGNJ) |->
        (fres_o == {$past(opb_i[HW-1]), $past(opa_i[MAG_W-1:0])}));

    p_sgnjn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_SGNJN) |->
        (fres_o[HW-1] != $past(opb_i[HW-1])));

    p_body_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) <= OP_SGNJX) |->
        (fres_o[MAG_W-1:0] == $past(opa_i[MAG_W-1:0])));

    p_min_pick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_MIN) |->
        (fres_o == $past(opa_i) || fres_o == $past(opb_i)));

    p_max_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_MAX) |->
        (fres_o == $past(opa_i) || fres_o == $past(opb_i)));

    p_bnan_pref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i) == OP_MIN || $past(op_i) == OP_MAX) &&
         (&$past(opb_i[14:10])) && (|$past(opb_i[9:0]))) |->
        (fres_o == $past(opa_i)));

    p_mvx_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_MVX) |->
        (xres_o[XW-1:HW] == {(XW-HW){xres_o[HW-1]}} && fres_o == '0));

    p_xres_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) != OP_MVX) |-> (xres_o == '0));

    p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) > OP_MVX) |-> (fres_o == '0));
endmodule

// File: tb/tb_hsm_unit.sv
`timescale 1ns/100ps
module tb_hsm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [15:0] opa_i = 16'h0;
    logic [15:0] opb_i = 16'h0;
    logic [15:0] fres_o;
    logic [63:0] xres_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hsm_unit dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .fres_o(fres_o), .xres_o(xres_o)
    );

    function automatic bit is_nan(logic [15:0] v);
        return (v[14:10] == 5'h1f) && (v[9:0] != 0);
    endfunction

    // Ordering key: signed integer where both zeros map to 0
    function automatic int key(logic [15:0] v);
        int m;
        m = int'(v[14:0]);
        return v[15] ? -m : m;
    endfunction

    function automatic logic [15:0] m_min(logic [15:0] a, logic [15:0] b);
        if (is_nan(b)) return a;
        if (!is_nan(a) && key(a) < key(b)) return a;
        return b;
    endfunction

    function automatic logic [15:0] m_max(logic [15:0] a, logic [15:0] b);
        if (is_nan(b)) return a;
        if (!is_nan(a) && key(b) <= key(a)) return a;
        return b;
    endfunction

    task automatic chk16(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk64(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one operation on a falling edge, sample at the next falling edge
    task automatic apply(logic [2:0] op, logic [15:0] a, logic [15:0] b);
        @(negedge clk);
        op_i = op; opa_i = a; opb_i = b;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        op_i = 3'd5; opa_i = 16'h8001; opb_i = 16'h0;
        repeat (3) @(negedge clk);
        chk16("R9 reset fres", fres_o, 16'h0);
        chk64("R9 reset xres", xres_o, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_inject();
        logic [15:0] av [4] = '{16'h3c00, 16'hc000, 16'h7e12, 16'h8001};
        logic [15:0] bv [4] = '{16'h8000, 16'h4000, 16'hfc00, 16'h7bff};
        for (int i = 0; i < 4; i++) begin
            apply(3'd0, av[i], bv[i]);
            chk16("R1 sgnj", fres_o, {bv[i][15], av[i][14:0]});
            chk64("R8 xres zero on sgnj", xres_o, 64'h0);
            apply(3'd1, av[i], bv[i]);
            chk16("R2 sgnjn", fres_o, {~bv[i][15], av[i][14:0]});
            apply(3'd2, av[i], bv[i]);
            chk16("R3 sgnjx", fres_o, {av[i][15] ^ bv[i][15], av[i][14:0]});
        end
    endtask

    task automatic t_minmax();
        logic [15:0] av [6] = '{16'h3c00, 16'hc000, 16'hfc00, 16'h0001, 16'h4000, 16'hbc00};
        logic [15:0] bv [6] = '{16'h4000, 16'h3c00, 16'h7c00, 16'h8001, 16'h4000, 16'hc000};
        for (int i = 0; i < 6; i++) begin
            apply(3'd3, av[i], bv[i]);
            chk16("R4 min", fres_o, m_min(av[i], bv[i]));
            apply(3'd4, av[i], bv[i]);
            chk16("R5 max", fres_o, m_max(av[i], bv[i]));
        end
        apply(3'd3, 16'h3c00, 16'h4000);
        chk16("R4 min literal", fres_o, 16'h3c00);
        apply(3'd4, 16'hfc00, 16'h7bff);
        chk16("R7 max vs -inf", fres_o, 16'h7bff);
    endtask

    task automatic t_nan();
        apply(3'd3, 16'h3c00, 16'h7e00);
        chk16("R6 min B qnan", fres_o, 16'h3c00);
        apply(3'd4, 16'hc000, 16'h7c01);
        chk16("R6 max B snan", fres_o, 16'hc000);
        apply(3'd3, 16'h7e00, 16'h4000);
        chk16("R6 min A nan", fres_o, 16'h4000);
        apply(3'd4, 16'hfe01, 16'hbc00);
        chk16("R6 max A nan", fres_o, 16'hbc00);
        apply(3'd3, 16'h7c05, 16'hffff);
        chk16("R6 min both nan", fres_o, 16'h7c05);
        apply(3'd4, 16'h7c00, 16'hfc00);
        chk16("R6 inf not nan", fres_o, 16'h7c00);
    endtask

    task automatic t_zero();
        apply(3'd3, 16'h0000, 16'h8000);
        chk16("R7 min +0,-0", fres_o, 16'h8000);
        apply(3'd3, 16'h8000, 16'h0000);
        chk16("R7 min -0,+0", fres_o, 16'h0000);
        apply(3'd4, 16'h0000, 16'h8000);
        chk16("R7 max +0,-0", fres_o, 16'h0000);
        apply(3'd4, 16'h8000, 16'h0000);
        chk16("R7 max -0,+0", fres_o, 16'h8000);
    endtask

    task automatic t_move();
        apply(3'd5, 16'h8001, 16'h1234);
        chk64("R8 move neg", xres_o, 64'hffff_ffff_ffff_8001);
        chk16("R8 move fres zero", fres_o, 16'h0);
        apply(3'd5, 16'h7fff, 16'hffff);
        chk64("R8 move pos", xres_o, 64'h0000_0000_0000_7fff);
    endtask

    task automatic t_unused();
        apply(3'd6, 16'h3c00, 16'h4000);
        chk16("R10 op6 fres", fres_o, 16'h0);
        chk64("R10 op6 xres", xres_o, 64'h0);
        apply(3'd7, 16'h8001, 16'h8001);
        chk16("R10 op7 fres", fres_o, 16'h0);
        chk64("R10 op7 xres", xres_o, 64'h0);
    endtask

    task automatic t_latency();
        apply(3'd0, 16'h3c00, 16'h8000);
        @(negedge clk);
        op_i = 3'd5; opa_i = 16'h8abc;
        #1;
        chk16("R9 holds before edge", fres_o, 16'hbc00);
        @(negedge clk);
        chk64("R9 updates after edge", xres_o, 64'hffff_ffff_ffff_8abc);
        rst_n = 1'b0;
        @(negedge clk);
        chk64("R9 mid-run reset", xres_o, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(5ns * 5000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_inject();
        t_minmax();
        t_nan();
        t_zero();
        t_move();
        t_unused();
        t_latency();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule